// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits behind the host bus of a flash-style memory controller. It turns a stream of host write cycles into device commands. A command is only taken after a fixed unlock handshake: byte AAh written at key address 5555h, then byte 55h written at key address 2AAAh. Short commands finish with a third write that carries the opcode. Erase and sector-protection commands use a setup byte, a second unlock pair, and then a final write that names the operation and, where needed, a sector. A completed command appears as a one-clock pulse that carries an enumerated code and a five-bit sector number. The engine that executes the command is a separate block.

The block also steers the read path to the memory array, the status register or the identification bytes. It serves the identification bytes itself, including the protection state of the two protectable sectors. While the execution engine reports busy, reads are forced onto the status path and only the abort command is passed through.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid is low and read_sel is 0 (array).
- R2: A write is taken only in a clock cycle where wr_en=1, ce_n=0, oe_n=1 and hv_en=1. Any other write is ignored and leaves the sequence position unchanged.
- R3: AAh at an address whose bits 14..0 equal 5555h, then 55h at bits 14..0 = 2AAAh, then a third write at 5555h decodes its data byte as follows: F0h read-reset (code 1), 90h identification (code 2), A0h page program (code 3), 70h read status (code 4), 50h clear status (code 5), E0h abort (code 6). Address bits 19..15 of these key writes are don't-care.
- R4: A third byte of 80h must be followed by a second AAh/55h pair. After that, 10h at 5555h issues chip erase (code 7), and 30h at any address issues sector erase (code 8).
- R5: A third byte of 60h must be followed by a second AAh/55h pair. After that, 20h issues protect (code 9) and 40h issues unprotect (code 10). Either one is issued only when address bits 19..15 of that write are 00000b or 11111b.
- R6: A taken write that does not fit the expected cycle returns the decoder to idle and issues no command. That write is not reused as a first cycle.
- R7: cmd_valid is high for exactly one clock, in the cycle after the edge that takes the final write. cmd_code and cmd_sector (address bits 19..15 of the final write) are valid while cmd_valid is high.
- R8: read_sel (0 array, 1 status, 2 ID) changes one clock after the pulse. Read-reset selects 0 and identification selects 2. Clear status leaves read_sel unchanged. Every other command selects 1.
- R9: While engine_busy is high, read_sel shows 1. A sequence that completes while busy is dropped, except abort, which is still issued. An 80h or 60h setup byte that arrives while busy sends the decoder back to idle.
- R10: id_data depends on id_offset. Offset 0 gives C2h and offset 1 gives F6h. Offset 2 gives C2h when id_sector is 0 and prot_lo=1, or when id_sector is 31 and prot_hi=1, and 00h otherwise. Offset 3 gives 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one clock per write |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a write |
| hv_en | input | 1 | Program/erase voltage present |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data byte |
| engine_busy | input | 1 | Execution engine is running a program or erase |
| prot_lo | input | 1 | Sector 0 is protected |
| prot_hi | input | 1 | Sector 31 is protected |
| id_sector | input | 5 | Sector field of the ID read address |
| id_offset | input | 2 | Word offset of the ID read address |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_code | output | 4 | Command code (values listed in R3, R4 and R5) |
| cmd_sector | output | 5 | Address bits 19..15 of the final write |
| read_sel | output | 2 | Read path select |
| id_data | output | 8 | Identification byte |

## Verification
The two functions that can meet in one cycle are the end of a command sequence and a busy indication from the execution engine. The bench raises engine_busy and then completes an identification sequence, an erase sequence and an abort sequence. It checks that only the abort pulses, and that read_sel stays on status for the whole busy window. A second overlap is a gated write that arrives in the middle of a sequence. The bench inserts writes with each of the three enables wrong between the unlock pair and the opcode, then checks that the next good opcode still completes the command.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  localparam int KEY_W  = 15;
  localparam int SECT_W = 5;
  localparam int ADDR_W = KEY_W + SECT_W;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_RDRST   = 4'd1,
    CMD_IDENT   = 4'd2,
    CMD_PGM     = 4'd3,
    CMD_RDSTAT  = 4'd4,
    CMD_CLRSTAT = 4'd5,
    CMD_ABORT   = 4'd6,
    CMD_CHIPERS = 4'd7,
    CMD_SECTERS = 4'd8,
    CMD_PROT    = 4'd9,
    CMD_UNPROT  = 4'd10
  } cmd_e;

  typedef enum logic [1:0] {
    RP_ARRAY  = 2'd0,
    RP_STATUS = 2'd1,
    RP_IDENT  = 2'd2
  } rpath_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_OPEN, SQ_SETUP, SQ_SETUP_KEY1, SQ_SETUP_OPEN
  } seq_e;

  // True when the low key bits of the address hit the given key.
  function automatic logic key_hit(input logic [ADDR_W-1:0] a,
                                   input logic [KEY_W-1:0] key);
    return a[KEY_W-1:0] == key;
  endfunction

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  // Only the bottom and the top sector carry a protect bit.
  function automatic logic protectable(input logic [SECT_W-1:0] s);
    return (s == '0) || (s == '1);
  endfunction

  function automatic rpath_e path_after(input cmd_e c, input rpath_e cur);
    case (c)
      CMD_NONE, CMD_CLRSTAT: return cur;
      CMD_RDRST:             return RP_ARRAY;
      CMD_IDENT:             return RP_IDENT;
      default:               return RP_STATUS;
    endcase
  endfunction

  function automatic logic [7:0] ident_byte(input logic [1:0] off,
                                            input logic [SECT_W-1:0] s,
                                            input logic plo, input logic phi,
                                            input logic [7:0] mfr,
                                            input logic [7:0] dev);
    case (off)
      2'd0:    return mfr;
      2'd1:    return dev;
      2'd2:    return (((s == '0) && plo) || ((s == '1) && phi)) ? mfr : 8'h00;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
  import ucd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [SECT_W-1:0] cmd_sector
);
  seq_e state_q, state_d;
  logic prot_kind_q, prot_kind_d;
  cmd_e found;
  cmd_e issued;

  // Events brought out by name for the checks below.
  logic at_key_a, first_key, second_key;
  logic seq_abandon;
  logic busy_drop;

  assign at_key_a   = key_hit(wr_addr, KEY_A);
  assign first_key  = at_key_a && (wr_data == 8'hAA);
  assign second_key = key_hit(wr_addr, KEY_B) && (wr_data == 8'h55);

  always_comb begin
    state_d     = state_q;
    prot_kind_d = prot_kind_q;
    found       = CMD_NONE;
    if (wr_fire) begin
      state_d = SQ_IDLE;
      case (state_q)
        SQ_IDLE:       if (first_key)  state_d = SQ_KEY1;
        SQ_KEY1:       if (second_key) state_d = SQ_OPEN;
        SQ_OPEN: if (at_key_a) begin
          case (wr_data)
            8'hF0: found = CMD_RDRST;
            8'h90: found = CMD_IDENT;
            8'hA0: found = CMD_PGM;
            8'h70: found = CMD_RDSTAT;
            8'h50: found = CMD_CLRSTAT;
            8'hE0: found = CMD_ABORT;
            8'h80: if (!busy) begin state_d = SQ_SETUP; prot_kind_d = 1'b0; end
            8'h60: if (!busy) begin state_d = SQ_SETUP; prot_kind_d = 1'b1; end
            default: found = CMD_NONE;
          endcase
        end
        SQ_SETUP:      if (first_key)  state_d = SQ_SETUP_KEY1;
        SQ_SETUP_KEY1: if (second_key) state_d = SQ_SETUP_OPEN;
        SQ_SETUP_OPEN: begin
          if (!prot_kind_q) begin
            if (wr_data == 8'h10 && at_key_a) found = CMD_CHIPERS;
            else if (wr_data == 8'h30)        found = CMD_SECTERS;
          end else if (protectable(sector_of(wr_addr))) begin
            if (wr_data == 8'h20)      found = CMD_PROT;
            else if (wr_data == 8'h40) found = CMD_UNPROT;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  assign busy_drop   = busy && (found != CMD_NONE) && (found != CMD_ABORT);
  assign issued      = busy_drop ? CMD_NONE : found;
  assign seq_abandon = wr_fire && (state_d == SQ_IDLE) && (found == CMD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      prot_kind_q <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_code    <= CMD_NONE;
      cmd_sector  <= '0;
    end else begin
      state_q     <= state_d;
      prot_kind_q <= prot_kind_d;
      cmd_valid   <= (issued != CMD_NONE);
      cmd_code    <= issued;
      cmd_sector  <= sector_of(wr_addr);
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9
  busy_only_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(busy) |-> cmd_code == CMD_ABORT);

  // R2
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(state_q) && !cmd_valid);

  // R5
  prot_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == CMD_PROT || cmd_code == CMD_UNPROT)
      |-> (cmd_sector == '0 || cmd_sector == '1));

  // R6
  abandon_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abandon |=> state_q == SQ_IDLE && !cmd_valid);
endmodule

// File: rtl/ucd_read_path.sv
module ucd_read_path
  import ucd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  cmd_e   cmd_code,
  input  logic   busy,
  output rpath_e read_sel
);
  rpath_e path_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         path_q <= RP_ARRAY;
    else if (cmd_valid) path_q <= path_after(cmd_code, path_q);
  end

  assign read_sel = busy ? RP_STATUS : path_q;

  // R8
  path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(path_q));

  // R8
  ident_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == CMD_IDENT |=> path_q == RP_IDENT);
endmodule

// File: rtl/ucd_ident.sv
module ucd_ident
  import ucd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF6
) (
  input  logic [1:0]        id_offset,
  input  logic [SECT_W-1:0] id_sector,
  input  logic              prot_lo,
  input  logic              prot_hi,
  output logic [7:0]        id_data
);
  assign id_data = ident_byte(id_offset, id_sector, prot_lo, prot_hi,
                              MFR_CODE, DEV_CODE);
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_A    = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B    = 15'h2AAA,
  parameter logic [7:0]       MFR_CODE = 8'hC2,
  parameter logic [7:0]       DEV_CODE = 8'hF6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              hv_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              engine_busy,
  input  logic              prot_lo,
  input  logic              prot_hi,
  input  logic [SECT_W-1:0] id_sector,
  input  logic [1:0]        id_offset,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [SECT_W-1:0] cmd_sector,
  output logic [1:0]        read_sel,
  output logic [7:0]        id_data
);
  logic   wr_fire;
  cmd_e   code_w;
  rpath_e path_w;

  assign wr_fire = wr_en && !ce_n && oe_n && hv_en;

  ucd_seq_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) i_seq (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(engine_busy), .cmd_valid(cmd_valid),
    .cmd_code(code_w), .cmd_sector(cmd_sector)
  );

  ucd_read_path i_path (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(code_w),
    .busy(engine_busy), .read_sel(path_w)
  );

  ucd_ident #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_id (
    .id_offset(id_offset), .id_sector(id_sector), .prot_lo(prot_lo),
    .prot_hi(prot_hi), .id_data(id_data)
  );

  assign cmd_code = code_w;
  assign read_sel = path_w;
endmodule

// File: tb/test_unlock_cmd_decoder.sv
module test_unlock_cmd_decoder;
  localparam int CLK_NS = 10;
  localparam int NV = 19;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ce_n = 1, oe_n = 1, hv_en = 1;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic engine_busy = 0, prot_lo = 0, prot_hi = 0;
  logic [4:0] id_sector = '0;
  logic [1:0] id_offset = '0;
  logic cmd_valid;
  logic [3:0] cmd_code;
  logic [4:0] cmd_sector;
  logic [1:0] read_sel;
  logic [7:0] id_data;
  int total = 0, fails = 0;
  bit done = 0;

  unlock_cmd_decoder i_unlock_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ce_n(ce_n), .oe_n(oe_n),
    .hv_en(hv_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .engine_busy(engine_busy), .prot_lo(prot_lo), .prot_hi(prot_hi),
    .id_sector(id_sector), .id_offset(id_offset), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_sector(cmd_sector), .read_sel(read_sel),
    .id_data(id_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Vector table: length, third byte, final address, final byte (6-cycle),
  // expected code, sector and read path afterwards.
  // R3 rows 0-8, R4 rows 9-13, R5 rows 14-18, R8 path column throughout.
  localparam logic [2:0]  V_LEN [NV] = '{3,3,3,3,3,3,3,3,3,6,3,6,3,6,6,6,3,6,6};
  localparam logic [7:0]  V_D3  [NV] = '{8'hF0,8'h90,8'h50,8'h70,8'hF0,8'hA0,8'hE0,
    8'h90,8'h33,8'h80,8'hF0,8'h80,8'hF0,8'h80,8'h60,8'h60,8'hF0,8'h60,8'h60};
  localparam logic [19:0] V_A   [NV] = '{20'h05555,20'h05555,20'h05555,20'h05555,
    20'h85555,20'h05555,20'h05555,20'h05555,20'h05555,20'h05555,20'h05555,
    20'h48000,20'h05555,20'h02AAA,20'hF8000,20'h00000,20'h05555,20'h48000,20'h05555};
  localparam logic [7:0]  V_D   [NV] = '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,
    8'h00,8'h00,8'h10,8'h00,8'h30,8'h00,8'h10,8'h20,8'h40,8'h00,8'h20,8'h10};
  localparam logic [3:0]  V_EC  [NV] = '{1,2,5,4,1,3,6,2,0,7,1,8,1,0,9,10,1,0,0};
  localparam logic [4:0]  V_ES  [NV] = '{0,0,0,0,16,0,0,0,0,0,0,9,0,0,31,0,0,0,0};
  localparam logic [1:0]  V_EP  [NV] = '{0,2,2,1,0,1,1,2,2,1,0,1,0,0,1,1,0,0,0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrg(input logic [19:0] a, input logic [7:0] d,
                     input logic c, input logic o, input logic h);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; ce_n = c; oe_n = o; hv_en = h;
    @(negedge clk);
    wr_en = 0; ce_n = 1; oe_n = 1; hv_en = 1;
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    wrg(a, d, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic unlock();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  initial begin
    #(CLK_NS*50000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd_valid", {31'd0, cmd_valid}, 0);
    check("R1 read_sel", {30'd0, read_sel}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      unlock();
      if (V_LEN[i] == 3) wr(V_A[i], V_D3[i]);
      else begin
        wr(20'h05555, V_D3[i]);
        unlock();
        wr(V_A[i], V_D[i]);
      end
      // R7 pulse in the cycle after the final write; R3 R4 R5 R6 decode
      check($sformatf("R7 R3 R4 R5 valid row %0d", i), {31'd0, cmd_valid}, (V_EC[i] != 0));
      if (V_EC[i] != 0) begin
        check($sformatf("R3 R4 R5 code row %0d", i), {28'd0, cmd_code}, V_EC[i]);
        check($sformatf("R7 sector row %0d", i), {27'd0, cmd_sector}, V_ES[i]);
      end
      @(negedge clk);
      check($sformatf("R7 single row %0d", i), {31'd0, cmd_valid}, 0);
      check($sformatf("R8 path row %0d", i), {30'd0, read_sel}, V_EP[i]);
    end

    // R2: gated writes between unlock and opcode are ignored
    unlock();
    wrg(20'h05555, 8'h90, 1'b1, 1'b1, 1'b1);
    check("R2 ce_n high", {31'd0, cmd_valid}, 0);
    wrg(20'h05555, 8'h90, 1'b0, 1'b0, 1'b1);
    check("R2 oe_n low", {31'd0, cmd_valid}, 0);
    wrg(20'h05555, 8'h90, 1'b0, 1'b1, 1'b0);
    check("R2 hv_en low", {31'd0, cmd_valid}, 0);
    wr(20'h05555, 8'h70);
    check("R2 sequence kept", {28'd0, cmd_code}, 4);
    @(negedge clk);

    // R6: a wrong write is not reused as a first cycle
    unlock();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
    wr(20'h05555, 8'hF0);
    check("R6 restart not reused", {31'd0, cmd_valid}, 0);
    // R6: wrong second unlock in a 6-cycle sequence
    unlock();
    wr(20'h05555, 8'h80);
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h00);
    wr(20'h05555, 8'h10);
    check("R6 second pair broken", {31'd0, cmd_valid}, 0);
    unlock();
    wr(20'h05555, 8'hF0);
    check("R6 recovers", {28'd0, cmd_code}, 1);
    @(negedge clk);
    check("R8 array after reset cmd", {30'd0, read_sel}, 0);

    // R9: busy forces status path, drops all but abort
    engine_busy = 1;
    @(negedge clk);
    check("R9 status while busy", {30'd0, read_sel}, 1);
    unlock();
    wr(20'h05555, 8'h90);
    check("R9 ident dropped", {31'd0, cmd_valid}, 0);
    unlock();
    wr(20'h05555, 8'h80);
    unlock();
    wr(20'h05555, 8'h10);
    check("R9 erase dropped", {31'd0, cmd_valid}, 0);
    unlock();
    wr(20'h05555, 8'hE0);
    check("R9 abort valid", {31'd0, cmd_valid}, 1);
    check("R9 abort code", {28'd0, cmd_code}, 6);
    @(negedge clk);
    engine_busy = 0;
    #1;
    check("R9 path after abort", {30'd0, read_sel}, 1);

    // R10 identification bytes
    id_offset = 2'd0; #1; check("R10 offset0", {24'd0, id_data}, 8'hC2);
    id_offset = 2'd1; #1; check("R10 offset1", {24'd0, id_data}, 8'hF6);
    id_offset = 2'd2; id_sector = 5'd0; prot_lo = 1; #1;
    check("R10 bottom protected", {24'd0, id_data}, 8'hC2);
    id_sector = 5'd31; prot_hi = 0; #1;
    check("R10 top unprotected", {24'd0, id_data}, 8'h00);
    prot_hi = 1; #1;
    check("R10 top protected", {24'd0, id_data}, 8'hC2);
    id_sector = 5'd5; #1;
    check("R10 middle sector", {24'd0, id_data}, 8'h00);
    id_offset = 2'd3; id_sector = 5'd0; #1;
    check("R10 offset3", {24'd0, id_data}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule